// File: doc/BRIEF.md
# Interruption Status-Word Swap Controller

This block owns the 128-bit status word of a processor (the word that holds the next instruction address, the protection key, the interruption enable masks and the wait flag). It also carries out the storage swap that takes an interruption. Six interruption classes raise one-cycle request pulses. Each pulse is latched as pending. When the controller is idle, it picks the highest-priority pending class that the current status word enables. It writes the current word to that class's save slot in low storage, then reads a replacement word from the class's handler slot and makes it current.

A handler returns by presenting a saved word on the load path. The controller checks every word that would become current, whether it comes from the load path or from storage. A word that has a reserved bit set is refused and raises a one-cycle format-fault pulse. While a swap is in progress, the busy output holds off instruction fetch. The wait flag in the current word also holds off fetch.

Top module: `psw_swap_ctrl`

Bit numbering: bit n of the status word is counted from the most significant end and sits at vector index 127-n.

## Requirements
- R1: After a synchronous reset, the status word is all zeros, `busy_o` is 0, no class is pending, `mem_req_o` is 0 and `fetch_en_o` is 1.
- R2: The instruction address is bits 64-127 (vector [63:0]) and the protection key is bits 8-11 (vector [119:116]). `fetch_en_o` is 1 exactly when the controller is idle and bit 14 (wait, vector [113]) is 0.
- R3: Class codes are restart 0, external 1, supervisor call 2, program 3, machine check 4 and I/O 5. The save slot of class c is at byte address SLOT_BASE + 32*c and its handler slot is 16 bytes above that.
- R4: A swap starts at a clock edge where the controller is idle, the load path is not valid and an enabled class is pending. It then runs as follows. The next cycle has `take_o`=1 and a write of the current word to the save slot. The cycle after that is a read of the handler slot. The read data, which arrives on `mem_rdata_i` one cycle after the read, becomes current at the end of the third cycle. `busy_o` is 1 for exactly these three cycles.
- R5: A request pulse stays pending until its class is taken. A masked class stays pending and is taken once a status word enables it.
- R6: I/O is enabled by bit 6 (vector [121]), external by bit 7 (vector [120]) and machine check by bit 13 (vector [114]). Supervisor call, program and restart cannot be masked.
- R7: When several enabled classes are pending, the order is machine check, supervisor call, program, external, I/O, then restart.
- R8: While idle, a valid load-path word that passes the format check becomes current at the next edge. A load in that cycle takes precedence over starting a swap.
- R9: The load path is ignored while `busy_o` is 1.
- R10: Bits 0, 2-4, 24-30 and 33-63 are reserved. A load-path word with any of these bits set leaves the status word unchanged, pulses `spec_exc_o` in the following cycle and makes the program class pending.
- R11: A handler-slot word with a reserved bit set is not made current: the interrupted word stays. `spec_exc_o` pulses in the following cycle and no class is made pending.
- R12: The status word does not change during the write and read cycles of a swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 6 | Request pulse per class, indexed by class code |
| ld_valid_i | input | 1 | Load-path word valid |
| ld_psw_i | input | 128 | Word to make current on the load path |
| mem_req_o | output | 1 | Storage access this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Storage byte address |
| mem_wdata_o | output | 128 | Storage write data (current word) |
| mem_rdata_i | input | 128 | Read data, one cycle after the read |
| psw_o | output | 128 | Current status word |
| busy_o | output | 1 | Swap in progress |
| fetch_en_o | output | 1 | Instruction fetch allowed |
| take_o | output | 1 | First cycle of a swap |
| take_cls_o | output | 3 | Class code being taken |
| spec_exc_o | output | 1 | Format-fault pulse |

## Verification
The assertions assume that storage returns read data exactly one cycle after a read request. They also assume that reset is applied at time zero, before any request or load. The bench's storage model keeps to the one-cycle read latency. The bench drives request and load pulses only at falling edges, each lasting one cycle. It preloads all handler slots before any interruption is raised. To exercise the format fault without breaking these assumptions, it plants one handler word with a reserved bit set on purpose.

// File: rtl/pswx_pkg.sv
package pswx_pkg;

    localparam int PSW_W  = 128;
    localparam int N_CLS  = 6;
    localparam int CLS_W  = 3;

    // vector index of architectural bit n is PSW_W-1-n
    localparam int IX_IO_EN  = PSW_W - 1 - 6;
    localparam int IX_EXT_EN = PSW_W - 1 - 7;
    localparam int IX_MCK_EN = PSW_W - 1 - 13;
    localparam int IX_WAIT   = PSW_W - 1 - 14;

    typedef logic [PSW_W-1:0] psw_t;

    typedef enum logic [CLS_W-1:0] {
        CL_RESTART = 3'd0,
        CL_EXT     = 3'd1,
        CL_SVC     = 3'd2,
        CL_PROG    = 3'd3,
        CL_MCHK    = 3'd4,
        CL_IO      = 3'd5
    } cls_e;

    typedef enum logic [1:0] {
        SW_IDLE,
        SW_STORE,
        SW_FETCH,
        SW_LOAD
    } sw_state_e;

    typedef struct packed {
        logic io;
        logic ext;
        logic mck;
    } gate_t;

    function automatic psw_t rsv_mask();
        psw_t m;
        m = '0;
        for (int n = 0; n < PSW_W; n++) begin
            if (n == 0 || (n >= 2 && n <= 4) || (n >= 24 && n <= 30) ||
                (n >= 33 && n <= 63))
                m[PSW_W-1-n] = 1'b1;
        end
        return m;
    endfunction

    localparam psw_t RSV_MASK = rsv_mask();

    // rank 0 is the most urgent
    function automatic cls_e rank_cls(int r);
        case (r)
            0:       return CL_MCHK;
            1:       return CL_SVC;
            2:       return CL_PROG;
            3:       return CL_EXT;
            4:       return CL_IO;
            default: return CL_RESTART;
        endcase
    endfunction

    function automatic gate_t gates_of(psw_t p);
        gate_t g;
        g.io  = p[IX_IO_EN];
        g.ext = p[IX_EXT_EN];
        g.mck = p[IX_MCK_EN];
        return g;
    endfunction

endpackage

// File: rtl/pswx_arbiter.sv
module pswx_arbiter
    import pswx_pkg::*;
(
    input  logic [N_CLS-1:0] pend_i,
    input  gate_t            gate_i,
    output logic             hit_o,
    output cls_e             cls_o
);

    logic [N_CLS-1:0] allow;
    logic [N_CLS-1:0] live;

    always_comb begin
        allow          = '1;
        allow[CL_IO]   = gate_i.io;
        allow[CL_EXT]  = gate_i.ext;
        allow[CL_MCHK] = gate_i.mck;
    end

    assign live = pend_i & allow;

    // walk from least to most urgent so the most urgent wins
    always_comb begin
        hit_o = 1'b0;
        cls_o = CL_RESTART;
        for (int r = N_CLS - 1; r >= 0; r--) begin
            if (live[rank_cls(r)]) begin
                hit_o = 1'b1;
                cls_o = rank_cls(r);
            end
        end
    end

endmodule

// File: rtl/pswx_fmtchk.sv
module pswx_fmtchk
    import pswx_pkg::*;
(
    input  psw_t cand_i,
    output logic ok_o
);

    assign ok_o = ((cand_i & RSV_MASK) == '0);

endmodule

// File: rtl/pswx_seq.sv
module pswx_seq
    import pswx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hit_i,
    input  logic      ld_i,
    output logic      start_o,
    output sw_state_e st_o
);

    sw_state_e st;

    assign start_o = (st == SW_IDLE) && !ld_i && hit_i;
    assign st_o    = st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SW_IDLE;
        end else begin
            unique case (st)
                SW_IDLE:  if (start_o) st <= SW_STORE;
                SW_STORE: st <= SW_FETCH;
                SW_FETCH: st <= SW_LOAD;
                SW_LOAD:  st <= SW_IDLE;
                default:  st <= SW_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/psw_swap_ctrl.sv
module psw_swap_ctrl
    import pswx_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SLOT_BASE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CLS-1:0]  irq_i,
    input  logic              ld_valid_i,
    input  logic [PSW_W-1:0]  ld_psw_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [PSW_W-1:0]  mem_wdata_o,
    input  logic [PSW_W-1:0]  mem_rdata_i,
    output logic [PSW_W-1:0]  psw_o,
    output logic              busy_o,
    output logic              fetch_en_o,
    output logic              take_o,
    output logic [CLS_W-1:0]  take_cls_o,
    output logic              spec_exc_o
);

    localparam int SLOT_STRIDE = 32;
    localparam int NEW_OFS     = SLOT_STRIDE / 2;

    sw_state_e        st;
    logic             start;
    logic             hit;
    cls_e             pick;
    cls_e             cls_q;
    psw_t             psw_q;
    logic [N_CLS-1:0] pend_q;
    logic [N_CLS-1:0] clr;
    logic [N_CLS-1:0] setp;
    logic             spec_q;
    logic             ld_go;
    psw_t             cand;
    logic             cand_ok;
    logic [ADDR_W-1:0] old_addr;

    pswx_arbiter u_arb (
        .pend_i (pend_q),
        .gate_i (gates_of(psw_q)),
        .hit_o  (hit),
        .cls_o  (pick)
    );

    pswx_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .hit_i   (hit),
        .ld_i    (ld_valid_i),
        .start_o (start),
        .st_o    (st)
    );

    assign cand = (st == SW_LOAD) ? mem_rdata_i : ld_psw_i;

    pswx_fmtchk u_chk (
        .cand_i (cand),
        .ok_o   (cand_ok)
    );

    assign ld_go = ld_valid_i && (st == SW_IDLE);
    assign clr   = start ? (N_CLS'(1) << pick) : '0;
    assign setp  = (ld_go && !cand_ok) ? (N_CLS'(1) << CL_PROG) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            psw_q  <= '0;
            pend_q <= '0;
            cls_q  <= CL_RESTART;
            spec_q <= 1'b0;
        end else begin
            spec_q <= 1'b0;
            if (start) cls_q <= pick;
            if (st == SW_LOAD || ld_go) begin
                if (cand_ok) psw_q <= cand;
                else         spec_q <= 1'b1;
            end
            pend_q <= (pend_q & ~clr) | irq_i | setp;
        end
    end

    assign old_addr    = ADDR_W'(SLOT_BASE) + ADDR_W'(int'(cls_q) * SLOT_STRIDE);
    assign mem_addr_o  = (st == SW_FETCH) ? old_addr + ADDR_W'(NEW_OFS) : old_addr;
    assign mem_req_o   = (st == SW_STORE) || (st == SW_FETCH);
    assign mem_we_o    = (st == SW_STORE);
    assign mem_wdata_o = psw_q;
    assign psw_o       = psw_q;
    assign busy_o      = (st != SW_IDLE);
    assign fetch_en_o  = !busy_o && !psw_q[IX_WAIT];
    assign take_o      = (st == SW_STORE);
    assign take_cls_o  = cls_q;
    assign spec_exc_o  = spec_q;

    // R4: the handler-slot read follows the save write, 16 bytes above it
    p_fetch_after_store_r4: assert property (@(posedge clk) disable iff (rst)
        take_o |=> (mem_req_o && !mem_we_o &&
                    mem_addr_o == $past(mem_addr_o) + ADDR_W'(NEW_OFS)));

    // R4: a swap begins with the take cycle and ends after the read-data cycle
    p_swap_opens_with_take_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> take_o);

    p_swap_closes_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !mem_req_o) |=> !busy_o);

    // R10: no word with a reserved bit ever becomes current
    p_current_well_formed_r10: assert property (@(posedge clk) disable iff (rst)
        (psw_q & RSV_MASK) == '0);

    // R6: maskable classes are taken only when their enable is set
    p_io_needs_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (take_o && take_cls_o == CL_IO) |-> psw_q[IX_IO_EN]);

    p_mchk_needs_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (take_o && take_cls_o == CL_MCHK) |-> psw_q[IX_MCK_EN]);

    // R12: status word frozen during the write and read cycles
    p_frozen_in_swap_r12: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |=> $stable(psw_o));

endmodule

// File: tb/sim_psw_swap_ctrl.sv
module sim_psw_swap_ctrl;

    logic         clk = 1'b0;
    logic         rst;
    logic [5:0]   irq;
    logic         ldv;
    logic [127:0] ldd;
    logic         mem_req, mem_we;
    logic [15:0]  mem_addr;
    logic [127:0] mem_wdata, mem_rdata;
    logic [127:0] psw;
    logic         busy, fetch_en, take, spec;
    logic [2:0]   take_cls;

    always #10 clk = ~clk;

    psw_swap_ctrl u0 (
        .clk(clk), .rst(rst), .irq_i(irq), .ld_valid_i(ldv), .ld_psw_i(ldd),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .psw_o(psw),
        .busy_o(busy), .fetch_en_o(fetch_en), .take_o(take),
        .take_cls_o(take_cls), .spec_exc_o(spec)
    );

    // storage: 16-byte slots, read data one cycle after the read
    logic [127:0] mem [0:15];
    logic         pre_we;
    logic [3:0]   pre_idx;
    logic [127:0] pre_dat;

    always @(posedge clk) begin
        if (pre_we) mem[pre_idx] <= pre_dat;
        if (mem_req && mem_we) mem[mem_addr[7:4]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:4]];
    end

    function automatic bit fmt_ok(logic [127:0] p);
        for (int n = 0; n < 128; n++)
            if ((n == 0 || (n >= 2 && n <= 4) || (n >= 24 && n <= 30) ||
                 (n >= 33 && n <= 63)) && p[127-n]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [127:0] mk(logic [63:0] ia, int key, bit io, bit ext,
                                        bit mck, bit wt);
        logic [127:0] p;
        p = '0;
        p[63:0]    = ia;
        p[119:116] = key[3:0];
        p[121]     = io;
        p[120]     = ext;
        p[114]     = mck;
        p[113]     = wt;
        return p;
    endfunction

    function automatic int pick_cls(bit [5:0] pend, logic [127:0] p);
        int order [6] = '{4, 2, 3, 1, 5, 0};
        for (int i = 0; i < 6; i++) begin
            int c = order[i];
            bit en = (c == 5) ? p[121] : (c == 1) ? p[120] : (c == 4) ? p[114] : 1'b1;
            if (pend[c] && en) return c;
        end
        return -1;
    endfunction

    // behavioural reference, advanced on each rising edge
    int           mph;
    bit [5:0]     mpend;
    logic [127:0] mpsw, mrd;
    int           mcls;
    bit           mspec;

    always @(posedge clk) begin
        bit [5:0] mclr, mset;
        bit       sn;
        int       s;
        if (rst) begin
            mph = 0; mpend = '0; mpsw = '0; mcls = 0; mspec = 0;
        end else begin
            mclr = '0; mset = '0; sn = 0;
            case (mph)
                0: begin
                    if (ldv) begin
                        if (fmt_ok(ldd)) mpsw = ldd;
                        else begin sn = 1; mset[3] = 1; end
                    end else begin
                        s = pick_cls(mpend, mpsw);
                        if (s >= 0) begin mcls = s; mclr[s] = 1; mph = 1; end
                    end
                end
                1: mph = 2;
                2: begin mrd = mem[mcls*2+1]; mph = 3; end
                default: begin
                    if (fmt_ok(mrd)) mpsw = mrd; else sn = 1;
                    mph = 0;
                end
            endcase
            mpend = (mpend & ~mclr) | irq | mset;
            mspec = sn;
        end
    end

    // per-cycle comparison against the reference
    int ctot = 0, cbad = 0;

    task automatic ccmp(string tag, logic [127:0] act, logic [127:0] exp);
        ctot++;
        if (act !== exp) begin
            cbad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            ccmp("R12 R8 status word", psw, mpsw);
            ccmp("R4 busy", 128'(busy), 128'(mph != 0));
            ccmp("R4 take", 128'(take), 128'(mph == 1));
            ccmp("R4 mem_req", 128'(mem_req), 128'(mph == 1 || mph == 2));
            ccmp("R2 fetch_en", 128'(fetch_en), 128'(mph == 0 && !mpsw[113]));
            ccmp("R10 R11 spec", 128'(spec), 128'(mspec));
            if (mph == 1) begin
                ccmp("R7 take_cls", 128'(take_cls), 128'(mcls));
                ccmp("R3 save addr", 128'(mem_addr), 128'(mcls * 32));
                ccmp("R4 save data", mem_wdata, mpsw);
                ccmp("R4 write", 128'(mem_we), 128'(1));
            end
            if (mph == 2) begin
                ccmp("R3 handler addr", 128'(mem_addr), 128'(mcls * 32 + 16));
                ccmp("R4 read", 128'(mem_we), 128'(0));
            end
        end
    end

    // directed checks
    int dtot = 0, dbad = 0;

    task automatic dchk(string tag, logic [127:0] act, logic [127:0] exp);
        dtot++;
        if (act !== exp) begin
            dbad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic put(int idx, logic [127:0] v);
        @(negedge clk);
        pre_we = 1; pre_idx = 4'(idx); pre_dat = v;
        @(negedge clk);
        pre_we = 0;
    endtask

    task automatic load(logic [127:0] v);
        @(negedge clk);
        ldv = 1; ldd = v;
        @(negedge clk);
        ldv = 0;
    endtask

    task automatic pulse(logic [5:0] m);
        @(negedge clk);
        irq = m;
        @(negedge clk);
        irq = '0;
    endtask

    int wd = 0;
    bit done = 0;
    always @(posedge clk) begin
        wd++;
        if (wd == 20000 && !done) begin
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", ctot + dtot + 1, cbad + dbad + 1);
            $finish;
        end
    end

    logic [127:0] npsw [6];
    logic [127:0] pa, bad_ld;

    initial begin
        rst = 1; irq = '0; ldv = 0; ldd = '0; pre_we = 0; pre_idx = '0; pre_dat = '0;
        mem_rdata = '0;
        cyc(3);
        rst = 0;
        @(negedge clk);
        dchk("R1 reset psw", psw, '0);
        dchk("R1 reset busy", 128'(busy), 0);
        dchk("R1 reset mem_req", 128'(mem_req), 0);
        dchk("R1 reset fetch_en", 128'(fetch_en), 1);

        for (int c = 0; c < 6; c++) begin
            npsw[c] = mk(64'h8000 + 64'(c * 256), c, 0, 0, 0, 0);
            if (c == 0) npsw[c][127-30] = 1'b1;   // reserved bit: faulty handler word
            put(c * 2 + 1, npsw[c]);
        end
        cyc(4);
        dchk("R1 nothing pending", 128'(busy), 0);

        pa = mk(64'h1000, 5, 1, 1, 1, 0);
        load(pa);
        dchk("R8 load", psw, pa);

        pulse(6'b100000);                 // I/O
        cyc(8);
        dchk("R4 io handler current", psw, npsw[5]);
        dchk("R3 io save slot", mem[10], pa);

        load(mem[10]);
        dchk("R8 resume", psw, pa);

        pulse(6'b110110);                 // ext, svc, mchk, io together
        cyc(16);
        dchk("R7 mchk saved first", mem[8], pa);
        dchk("R7 svc after mchk", mem[4], npsw[4]);
        dchk("R7 svc handler current", psw, npsw[2]);
        cyc(6);
        dchk("R6 masked stay idle", 128'(busy), 0);
        dchk("R6 masked psw", psw, npsw[2]);

        load(pa);                          // enables all: ext before io
        cyc(8);
        dchk("R7 ext before io", psw, npsw[1]);
        dchk("R3 ext save slot", mem[2], pa);
        load(pa);
        cyc(8);
        dchk("R5 io held pending", psw, npsw[5]);
        dchk("R5 io save slot", mem[10], pa);

        pulse(6'b000100);                  // svc
        cyc(1);
        load(mk(64'h7777, 3, 1, 1, 1, 0)); // arrives while busy
        cyc(6);
        dchk("R9 load ignored in swap", psw, npsw[2]);

        bad_ld = pa;
        bad_ld[127-30] = 1'b1;
        load(bad_ld);
        dchk("R10 fault pulse", 128'(spec), 1);
        dchk("R10 word kept", psw, npsw[2]);
        cyc(8);
        dchk("R10 program taken", psw, npsw[3]);
        dchk("R10 program save slot", mem[6], npsw[2]);

        pulse(6'b000001);                  // restart, faulty handler word
        cyc(8);
        dchk("R11 word kept", psw, npsw[3]);
        dchk("R11 restart save slot", mem[0], npsw[3]);
        dchk("R11 no new swap", 128'(busy), 0);

        load(mk(64'h2468, 9, 0, 0, 0, 1));
        dchk("R2 wait blocks fetch", 128'(fetch_en), 0);
        dchk("R2 address field", 128'(psw[63:0]), 128'(64'h2468));
        dchk("R2 key field", 128'(psw[119:116]), 128'(9));

        cyc(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", ctot + dtot, cbad + dbad);
        $finish;
    end

endmodule